// File: doc/BRIEF.md
# Serial Port Modem Control and Diagnostic Loop

This block holds the modem-control byte of a 16550-class serial port and owns the routing between the transmit shifter, the receive shifter and the serial and modem pins. Software writes and reads the control byte at address offset 4. Bits 0 and 1 drive the active-low terminal-ready and request-to-send pins. Bit 2 is a plain storage bit. Bit 3 gates the serial-port interrupt output.

The block also presents a modem status byte at offset 6. It carries the active-high levels of the four modem inputs together with change flags, and the change flags can raise a modem-status interrupt request. The four external modem inputs pass through synchronizers before their changes are detected.

Setting bit 4 puts the port into diagnostic loop mode. The transmit line idles at mark and the transmit shifter feeds the receiver directly. The external modem inputs are replaced by the control bits, and every outgoing modem pin is forced inactive. The status byte and its change flags keep working in this mode, with the control bits as their source.

Top module: `uart_modem_ctl`

## Requirements
- R1: After reset the control byte reads 0, dtrOut_n and rtsOut_n are 1, irqOutEn is 0, loop mode is off and the status byte reads 0 while all modem inputs are high.
- R2: A write at offset 4 stores bits 4:0. Bits 7:5 ignore writes and always read 0. The stored value is visible from the cycle after the write.
- R3: Outside loop mode, dtrOut_n equals the inverse of control bit 0 and rtsOut_n equals the inverse of control bit 1.
- R4: Outside loop mode, irqOutEn equals control bit 3. irqOut always carries uartIrq.
- R5: With loop off, txdPin follows txShiftOut and rxShiftIn follows rxdPin. With loop on (bit 4 = 1), txdPin is 1 and rxShiftIn follows txShiftOut, whatever rxdPin does.
- R6: In loop mode, dtrOut_n and rtsOut_n are 1 and irqOutEn is 0, whatever the other control bits hold.
- R7: The status byte at offset 6 holds active-high CTS in bit 4, DSR in bit 5, RI in bit 6 and DCD in bit 7. These are the inverses of the active-low inputs and become visible two clock edges after the input changes.
- R8: In loop mode the external modem inputs are ignored. Status DSR is control bit 0, CTS is bit 1, RI is bit 2 and DCD is bit 3.
- R9: Status bit 0 flags a CTS change, bit 1 a DSR change, bit 2 a 1-to-0 transition of RI, and bit 3 a DCD change. A flag is set on the clock edge after the status level changes and stays set until it is cleared.
- R10: A read at offset 6 clears all change flags at the end of the read cycle. A change detected on that same edge leaves its flag set.
- R11: msIrq is 1 exactly when msIntEn is 1 and at least one change flag is set. This holds in loop mode as well.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 3 | Register offset |
| regWrEn | input | 1 | Write strobe |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Read strobe (clears change flags at offset 6) |
| regRdData | output | 8 | Read data for the addressed register |
| ctsIn_n | input | 1 | Clear-to-send input, active low |
| dsrIn_n | input | 1 | Data-set-ready input, active low |
| riIn_n | input | 1 | Ring indicator input, active low |
| dcdIn_n | input | 1 | Carrier detect input, active low |
| dtrOut_n | output | 1 | Terminal-ready output, active low |
| rtsOut_n | output | 1 | Request-to-send output, active low |
| txShiftOut | input | 1 | Serial output of the transmit shifter |
| rxdPin | input | 1 | Receive data pin |
| txdPin | output | 1 | Transmit data pin |
| rxShiftIn | output | 1 | Serial input to the receive shifter |
| uartIrq | input | 1 | Combined interrupt request of the port |
| irqOut | output | 1 | Interrupt output value |
| irqOutEn | output | 1 | Interrupt output enable (0 = high impedance) |
| msIntEn | input | 1 | Modem-status interrupt enable |
| msIrq | output | 1 | Modem-status interrupt request |

## Verification
The flag clear caused by a status read and a newly detected modem change can land on the same clock edge. The bench provokes this by starting a status read exactly two edges after an input falls. At that point the synchronized level is already visible, but its change flag is set only by the edge that ends the read. The read is expected to return the level without the flag. The next read must return the flag still set, showing that set wins over clear. Loop-mode writes that change several control bits at once exercise the same priority through the internal source.

// File: rtl/modem_ctl_pkg.sv
package modem_ctl_pkg;
  // positions inside the four-bit modem line vector (also status byte order)
  localparam int LINE_CTS = 0;
  localparam int LINE_DSR = 1;
  localparam int LINE_RI  = 2;
  localparam int LINE_DCD = 3;
  localparam int NUM_LINES = 4;

  // control byte field positions
  localparam int CB_DTR  = 0;
  localparam int CB_RTS  = 1;
  localparam int CB_AUX  = 2;
  localparam int CB_IRQE = 3;
  localparam int CB_LOOP = 4;
  localparam int CB_BITS = 5;

  typedef struct packed {
    logic selCtl;
    logic selStat;
    logic wrCtl;
    logic rdStat;
  } ctlStrobes_t;
endpackage

// File: rtl/modem_ctl_ctrl.sv
module modem_ctl_ctrl
  import modem_ctl_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int CTL_OFFSET  = 4,
  parameter int STAT_OFFSET = 6
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output ctlStrobes_t       stb
);
  localparam logic [ADDR_W-1:0] CTL_ADR  = ADDR_W'(CTL_OFFSET);
  localparam logic [ADDR_W-1:0] STAT_ADR = ADDR_W'(STAT_OFFSET);

  always_comb begin
    stb.selCtl  = (regAddr == CTL_ADR);
    stb.selStat = (regAddr == STAT_ADR);
    stb.wrCtl   = regWrEn & stb.selCtl;
    stb.rdStat  = regRdEn & stb.selStat;
  end
endmodule

// File: rtl/modem_ctl_dp.sv
module modem_ctl_dp
  import modem_ctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t stb,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic [NUM_LINES-1:0] lineIn_n,
  output logic        dtrOut_n,
  output logic        rtsOut_n,
  input  logic        txShiftOut,
  input  logic        rxdPin,
  output logic        txdPin,
  output logic        rxShiftIn,
  input  logic        uartIrq,
  output logic        irqOut,
  output logic        irqOutEn,
  input  logic        msIntEn,
  output logic        msIrq
);
  logic [CB_BITS-1:0]   ctlQ;
  logic [NUM_LINES-1:0] syncQ [SYNC_STAGES];
  logic [NUM_LINES-1:0] extLvl, loopLvl, statNow, statPrev, deltaQ, deltaHit;
  logic                 loopOn;

  assign loopOn = ctlQ[CB_LOOP];

  // control byte storage; upper bits are never stored
  always_ff @(posedge clk) begin
    if (!rstN)          ctlQ <= '0;
    else if (stb.wrCtl) ctlQ <= wrData[CB_BITS-1:0];
  end

  // external line synchronizer, active-high after inversion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
    end else begin
      syncQ[0] <= ~lineIn_n;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
    end
  end
  assign extLvl = syncQ[SYNC_STAGES-1];

  // loop substitution: DTR->DSR, RTS->CTS, AUX->RI, IRQE->DCD
  always_comb begin
    loopLvl           = '0;
    loopLvl[LINE_DSR] = ctlQ[CB_DTR];
    loopLvl[LINE_CTS] = ctlQ[CB_RTS];
    loopLvl[LINE_RI]  = ctlQ[CB_AUX];
    loopLvl[LINE_DCD] = ctlQ[CB_IRQE];
  end
  assign statNow = loopOn ? loopLvl : extLvl;

  // per-line change detection; the ring line reports trailing edges only
  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    if (i == LINE_RI) begin : g_trail
      assign deltaHit[i] = statPrev[i] & ~statNow[i];
    end else begin : g_any
      assign deltaHit[i] = statPrev[i] ^ statNow[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statPrev <= '0;
      deltaQ   <= '0;
    end else begin
      statPrev <= statNow;
      deltaQ   <= (stb.rdStat ? '0 : deltaQ) | deltaHit;
    end
  end

  // pins and serial routing
  assign dtrOut_n  = loopOn | ~ctlQ[CB_DTR];
  assign rtsOut_n  = loopOn | ~ctlQ[CB_RTS];
  assign irqOutEn  = ~loopOn & ctlQ[CB_IRQE];
  assign irqOut    = uartIrq;
  assign txdPin    = loopOn | txShiftOut;
  assign rxShiftIn = loopOn ? txShiftOut : rxdPin;
  assign msIrq     = msIntEn & (|deltaQ);

  always_comb begin
    rdData = '0;
    if (stb.selCtl)       rdData = {{(8-CB_BITS){1'b0}}, ctlQ};
    else if (stb.selStat) rdData = {statNow, deltaQ};
  end

  AST_WR_STORES: assert property (@(posedge clk) disable iff (!rstN)
    stb.wrCtl |=> ctlQ == $past(wrData[CB_BITS-1:0])); // R2
  AST_LOOP_PINS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.wrCtl) && $past(wrData[CB_LOOP]) |-> dtrOut_n && rtsOut_n && !irqOutEn && txdPin); // R6
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    !stb.rdStat |=> (($past(deltaQ) & ~deltaQ) == '0)); // R9
  AST_RI_TRAIL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(statNow[LINE_RI]) |=> deltaQ[LINE_RI]); // R9
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    stb.rdStat && (deltaHit == '0) |=> deltaQ == '0); // R10
  AST_MS_IRQ: assert property (@(posedge clk) disable iff (!rstN)
    (deltaQ == '0) |-> !msIrq); // R11
endmodule

// File: rtl/uart_modem_ctl.sv
module uart_modem_ctl
  import modem_ctl_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int CTL_OFFSET  = 4,
  parameter int STAT_OFFSET = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  logic              regRdEn,
  output logic [7:0]        regRdData,
  input  logic              ctsIn_n,
  input  logic              dsrIn_n,
  input  logic              riIn_n,
  input  logic              dcdIn_n,
  output logic              dtrOut_n,
  output logic              rtsOut_n,
  input  logic              txShiftOut,
  input  logic              rxdPin,
  output logic              txdPin,
  output logic              rxShiftIn,
  input  logic              uartIrq,
  output logic              irqOut,
  output logic              irqOutEn,
  input  logic              msIntEn,
  output logic              msIrq
);
  ctlStrobes_t          stb;
  logic [NUM_LINES-1:0] lineIn_n;

  always_comb begin
    lineIn_n           = '1;
    lineIn_n[LINE_CTS] = ctsIn_n;
    lineIn_n[LINE_DSR] = dsrIn_n;
    lineIn_n[LINE_RI]  = riIn_n;
    lineIn_n[LINE_DCD] = dcdIn_n;
  end

  modem_ctl_ctrl #(
    .ADDR_W(ADDR_W), .CTL_OFFSET(CTL_OFFSET), .STAT_OFFSET(STAT_OFFSET)
  ) u_ctrl (
    .regAddr(regAddr), .regWrEn(regWrEn), .regRdEn(regRdEn), .stb(stb)
  );

  modem_ctl_dp #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(regWrData), .rdData(regRdData),
    .lineIn_n(lineIn_n), .dtrOut_n(dtrOut_n), .rtsOut_n(rtsOut_n),
    .txShiftOut(txShiftOut), .rxdPin(rxdPin), .txdPin(txdPin), .rxShiftIn(rxShiftIn),
    .uartIrq(uartIrq), .irqOut(irqOut), .irqOutEn(irqOutEn),
    .msIntEn(msIntEn), .msIrq(msIrq)
  );
endmodule

// File: tb/test_uart_modem_ctl.sv
module test_uart_modem_ctl;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] regAddr = '0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0] regWrData = '0, regRdData;
  logic ctsIn_n = 1'b1, dsrIn_n = 1'b1, riIn_n = 1'b1, dcdIn_n = 1'b1;
  logic dtrOut_n, rtsOut_n, txdPin, rxShiftIn, irqOut, irqOutEn, msIrq;
  logic txShiftOut = 1'b1, rxdPin = 1'b1, uartIrq = 1'b0, msIntEn = 1'b0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] exp;
    string      tag;
  } rdItem_t;
  rdItem_t rdQueue[$];

  always #5 clk = ~clk;

  uart_modem_ctl i_uart_modem_ctl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .ctsIn_n(ctsIn_n), .dsrIn_n(dsrIn_n),
    .riIn_n(riIn_n), .dcdIn_n(dcdIn_n), .dtrOut_n(dtrOut_n), .rtsOut_n(rtsOut_n),
    .txShiftOut(txShiftOut), .rxdPin(rxdPin), .txdPin(txdPin), .rxShiftIn(rxShiftIn),
    .uartIrq(uartIrq), .irqOut(irqOut), .irqOutEn(irqOutEn), .msIntEn(msIntEn), .msIrq(msIrq)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wrCtl(input logic [7:0] d);
    regAddr = 3'd4; regWrData = d; regWrEn = 1'b1;
    tick();
    regWrEn = 1'b0;
  endtask

  // driver: queue the expected read data, then issue the read
  task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
    rdQueue.push_back('{exp: exp, tag: tag});
    regAddr = a; regRdEn = 1'b1;
    tick();
    regRdEn = 1'b0;
  endtask

  // monitor: compare read data away from the active edge
  always @(negedge clk) begin
    if (regRdEn) begin
      if (rdQueue.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: read with no expected item, actual %h expected none", regRdData);
      end else begin
        rdItem_t it;
        it = rdQueue.pop_front();
        check(regRdData, it.exp, it.tag);
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    while (!done && cyc < 5000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(); tick(); tick();
    rstN = 1'b1;
    tick();
    // R1 reset state
    check({7'b0, dtrOut_n}, 8'd1, "R1 dtr idle");
    check({7'b0, rtsOut_n}, 8'd1, "R1 rts idle");
    check({7'b0, irqOutEn}, 8'd0, "R1 irq disabled");
    check({7'b0, txdPin}, 8'd1, "R1 txd follows shifter");
    rd(3'd4, 8'h00, "R1 control reset");
    rd(3'd6, 8'h00, "R1 status reset");

    // R2 R3 R4: upper bits dropped, pin drive inverted, irq gate
    wrCtl(8'hEF);
    rd(3'd4, 8'h0F, "R2 reserved dropped");
    check({7'b0, dtrOut_n}, 8'd0, "R3 dtr asserted");
    check({7'b0, rtsOut_n}, 8'd0, "R3 rts asserted");
    check({7'b0, irqOutEn}, 8'd1, "R4 irq enabled");
    uartIrq = 1'b1; #1;
    check({7'b0, irqOut}, 8'd1, "R4 irq value");
    uartIrq = 1'b0;
    wrCtl(8'h02);
    check({7'b0, dtrOut_n}, 8'd1, "R3 dtr released");
    check({7'b0, rtsOut_n}, 8'd0, "R3 rts held");
    check({7'b0, irqOutEn}, 8'd0, "R4 irq gated off");

    // R5 normal serial path
    txShiftOut = 1'b0; rxdPin = 1'b1; #1;
    check({7'b0, txdPin}, 8'd0, "R5 txd normal");
    check({7'b0, rxShiftIn}, 8'd1, "R5 rx from pin");
    rxdPin = 1'b0; #1;
    check({7'b0, rxShiftIn}, 8'd0, "R5 rx from pin low");

    // R7 R9 R10: sync latency and same-edge set/clear
    ctsIn_n = 1'b0;
    tick(); tick();
    rd(3'd6, 8'h10, "R7 cts visible, R10 flag not yet");
    rd(3'd6, 8'h11, "R10 set wins over clear");
    rd(3'd6, 8'h10, "R10 cleared");

    // R9 ring: rising edge no flag, trailing edge flags
    riIn_n = 1'b0;
    tick(); tick(); tick();
    rd(3'd6, 8'h50, "R9 ring rise no flag");
    riIn_n = 1'b1;
    tick(); tick(); tick();
    rd(3'd6, 8'h14, "R9 ring trailing edge");
    rd(3'd6, 8'h10, "R10 ring flag cleared");

    // R7 R9 R11 dsr and dcd together
    dsrIn_n = 1'b0; dcdIn_n = 1'b0; msIntEn = 1'b1;
    tick(); tick(); tick();
    check({7'b0, msIrq}, 8'd1, "R11 irq on flags");
    rd(3'd6, 8'hBA, "R9 dsr dcd flags");
    check({7'b0, msIrq}, 8'd0, "R11 irq drops after read");
    rd(3'd6, 8'hB0, "R7 levels held");
    ctsIn_n = 1'b1; dsrIn_n = 1'b1; dcdIn_n = 1'b1;
    tick(); tick(); tick();
    rd(3'd6, 8'h0B, "R9 release flags");
    rd(3'd6, 8'h00, "R10 all clear");

    // R5 R6 loop mode routing
    wrCtl(8'h10);
    txShiftOut = 1'b0; rxdPin = 1'b1; #1;
    check({7'b0, txdPin}, 8'd1, "R5 txd mark in loop");
    check({7'b0, rxShiftIn}, 8'd0, "R5 rx from shifter");
    txShiftOut = 1'b1; rxdPin = 1'b0; #1;
    check({7'b0, rxShiftIn}, 8'd1, "R5 rxd ignored in loop");
    ctsIn_n = 1'b0;
    tick(); tick(); tick();
    rd(3'd6, 8'h00, "R8 external ignored");

    // R8 R6 R11 loop substitution
    wrCtl(8'h1F);
    check({7'b0, dtrOut_n}, 8'd1, "R6 dtr inactive");
    check({7'b0, rtsOut_n}, 8'd1, "R6 rts inactive");
    check({7'b0, irqOutEn}, 8'd0, "R6 irq disabled");
    tick();
    check({7'b0, msIrq}, 8'd1, "R11 loop irq");
    msIntEn = 1'b0; #1;
    check({7'b0, msIrq}, 8'd0, "R11 masked");
    rd(3'd6, 8'hFB, "R8 all lines from control");
    rd(3'd6, 8'hF0, "R10 loop flags cleared");
    wrCtl(8'h1B);
    tick();
    rd(3'd6, 8'hB4, "R8 aux drives ring trailing");
    wrCtl(8'h11);
    tick();
    rd(3'd6, 8'h29, "R8 dtr maps to dsr");
    wrCtl(8'h12);
    tick();
    rd(3'd6, 8'h13, "R8 rts maps to cts");

    // leave loop: external cts still low
    wrCtl(8'h00);
    tick();
    rd(3'd6, 8'h10, "R7 external restored");
    wrCtl(8'hE0);
    rd(3'd4, 8'h00, "R2 reserved only write");

    tick();
    if (rdQueue.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", rdQueue.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule